// File: doc/BRIEF.md
# Snoop Inquire MESI Responder

This block answers bus snoop inquiries on behalf of a write-back data cache whose lines carry a four-state MESI tag. When a snoop strobe arrives with an address and an invalidate flag, the block reads the tag and state of the addressed set from an external direct-mapped array. It then drives two active-low results, hit and hit-modified. A dirty line is first handed to a writeback engine as a full-line request, and only after the engine reports completion is the line's state rewritten. The new state is invalid when the invalidate flag was set and shared when it was clear. A miss leaves the array untouched.

Two further situations are handled. A snoop can land on a line whose fill is still under way and so is not yet in the array. The block then reports a hit and raises a sticky flag telling the fill engine to install that line as shared, or not to install it at all. Exclusive is never allowed. Before a locked operation, the requester holds a lock request with the target address. The block purges that line (writeback if dirty, then invalidate) and pulses an acknowledge, so a later snoop can never find the locked line resident.

The control is one state machine with six states. IDLE waits for work. READ issues the array read. COMPARE evaluates the returned tag and state. WBACK holds the writeback request until it is done. WRITE stores the new state. DONE releases the results and acknowledges a lock. The transitions are:
- IDLE→READ on a snoop strobe, or on a lock request when no strobe is present.
- READ→COMPARE always.
- COMPARE→WBACK on a dirty hit, COMPARE→WRITE on a clean hit, and COMPARE→DONE on a miss.
- WBACK→WRITE when the writeback is done.
- WRITE→DONE always.
- DONE→IDLE always.

Top module: `snoop_responder`

## Requirements
- R1: After reset, hit_n and hitm_n are 1, and busy, wb_req, arr_wr_en, lock_ack, fill_shared and fill_drop are all 0.
- R2: A snoop strobe sampled in IDLE at clock edge k makes busy 1 from edge k onward. hit_n and hitm_n become valid after edge k+2 and are held until busy falls, at which point both return to 1. A line hits when the array tag equals addr[ADDR_W-1:OFF_W+IDX_W] and the state is not invalid. The set index is addr[OFF_W+IDX_W-1:OFF_W]. The state encoding is I=0, S=1, E=2, M=3.
- R3: On a snoop miss, hit_n and hitm_n both stay 1, no writeback is requested and the array is not written.
- R4: On a hit to an S or E line, hit_n is 0 and hitm_n is 1, and no writeback is requested. One WRITE cycle then stores S when snp_inv is 0, or I when snp_inv is 1.
- R5: On a hit to an M line, both hit_n and hitm_n are 0. wb_req is raised from edge k+2 with wb_addr set to the line address (offset bits zero). It is held until wb_done is sampled high.
- R6: hitm_n is never 0 while hit_n is 1.
- R7: While busy is 1, snoop strobes and lock requests are ignored. Neither starts a second operation nor changes any array line.
- R8: A snoop that misses the array but whose line matches fill_addr while fill_active is 1 drives hit_n 0 and hitm_n 1 and writes nothing. It sets fill_shared if snp_inv is 0. It sets fill_drop if snp_inv is 1, and this also clears fill_shared; drop dominates later snoops. Both flags clear on the edge after fill_active is sampled 0, and they are never both 1.
- R9: A lock request (a level held until lock_ack) is handled as follows. An M line is written back and then set to I. An S or E line is set to I with no writeback. A miss writes nothing. lock_ack is 1 for exactly the DONE cycle, and hit_n and hitm_n stay 1 throughout.
- R10: If a snoop strobe and a lock request are both present at the same IDLE edge, the snoop is served first and the lock operation starts at the first IDLE edge after it.
- R11: The array is written only in the single WRITE cycle, never while wb_req is 1, and never before wb_done has been sampled for a dirty line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_valid | input | 1 | Snoop strobe, one cycle |
| snp_addr | input | ADDR_W | Snoop address |
| snp_inv | input | 1 | Invalidate on hit |
| lock_req | input | 1 | Purge request ahead of a locked operation, held until lock_ack |
| lock_addr | input | ADDR_W | Locked operation target |
| lock_ack | output | 1 | Purge finished |
| hit_n | output | 1 | Active-low snoop hit |
| hitm_n | output | 1 | Active-low snoop hit to modified line |
| busy | output | 1 | Operation in progress |
| arr_rd_en | output | 1 | Array read enable |
| arr_rd_idx | output | IDX_W | Array read set index |
| arr_rd_tag | input | TAG_W | Tag returned one cycle after read |
| arr_rd_state | input | 2 | MESI state returned one cycle after read |
| arr_wr_en | output | 1 | Array state write enable |
| arr_wr_idx | output | IDX_W | Array write set index |
| arr_wr_state | output | 2 | New MESI state |
| wb_req | output | 1 | Full-line writeback request |
| wb_addr | output | ADDR_W | Line address to write back |
| wb_done | input | 1 | Writeback finished |
| fill_active | input | 1 | A line fill is in flight |
| fill_addr | input | ADDR_W | Address of the line being filled |
| fill_shared | output | 1 | Install the filling line as shared |
| fill_drop | output | 1 | Do not install the filling line |

## Verification
The hardest cases to reach are those that arrive while the block is already occupied or split across two engines. These are a strobe arriving during a stalled writeback, a snoop and a lock request landing on the same edge, and a snoop hitting a fill that has not reached the array. The bench owns the tag array and the writeback engine. It can therefore stall wb_done for several cycles and pulse a second snoop into that window. It can raise lock_req ahead of a snoop so both are sampled together. It can hold fill_active with a fill address whose set is empty, then issue snoops with each invalidate value before ending the fill.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

    typedef enum logic [1:0] {
        MESI_I = 2'd0,
        MESI_S = 2'd1,
        MESI_E = 2'd2,
        MESI_M = 2'd3
    } mesi_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_COMPARE,
        ST_WBACK,
        ST_WRITE,
        ST_DONE
    } resp_state_e;

endpackage

// File: rtl/snoop_line_match.sv
module snoop_line_match
    import snoop_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5,
    parameter int IDX_W  = 7,
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W,
    localparam int LINE_W = ADDR_W - OFF_W
) (
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [1:0]        rd_state,
    input  logic              fill_active,
    input  logic [ADDR_W-1:0] fill_addr,
    output logic              arr_hit,
    output logic              arr_dirty,
    output logic              fill_hit
);

    logic [TAG_W-1:0]  op_tag;
    logic [LINE_W-1:0] op_line;
    logic [LINE_W-1:0] fl_line;
    mesi_e             st;

    always_comb begin
        op_tag    = op_addr[ADDR_W-1:OFF_W+IDX_W];
        op_line   = op_addr[ADDR_W-1:OFF_W];
        fl_line   = fill_addr[ADDR_W-1:OFF_W];
        st        = mesi_e'(rd_state);
        arr_hit   = (rd_tag == op_tag) && (st != MESI_I);
        arr_dirty = arr_hit && (st == MESI_M);
        fill_hit  = fill_active && (fl_line == op_line);
    end

endmodule

// File: rtl/snoop_fill_tracker.sv
module snoop_fill_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic fill_active,
    input  logic set_en,
    input  logic set_inv,
    output logic fill_shared,
    output logic fill_drop
);

    always_ff @(posedge clk) begin
        if (!rst_n || !fill_active) begin
            fill_shared <= 1'b0;
            fill_drop   <= 1'b0;
        end else if (set_en) begin
            if (set_inv) begin
                fill_drop   <= 1'b1;
                fill_shared <= 1'b0;
            end else begin
                fill_shared <= !fill_drop;
            end
        end
    end

endmodule

// File: rtl/snoop_responder.sv
module snoop_responder
    import snoop_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int SETS       = 128,
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              snp_inv,
    input  logic              lock_req,
    input  logic [ADDR_W-1:0] lock_addr,
    output logic              lock_ack,
    output logic              hit_n,
    output logic              hitm_n,
    output logic              busy,
    output logic              arr_rd_en,
    output logic [IDX_W-1:0]  arr_rd_idx,
    input  logic [TAG_W-1:0]  arr_rd_tag,
    input  logic [1:0]        arr_rd_state,
    output logic              arr_wr_en,
    output logic [IDX_W-1:0]  arr_wr_idx,
    output logic [1:0]        arr_wr_state,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    input  logic              wb_done,
    input  logic              fill_active,
    input  logic [ADDR_W-1:0] fill_addr,
    output logic              fill_shared,
    output logic              fill_drop
);

    resp_state_e       state, state_nx;
    logic [ADDR_W-1:0] op_addr;
    logic              op_inv;
    logic              op_lock;
    logic              take_snp;
    logic              take_lock;
    logic              arr_hit;
    logic              arr_dirty;
    logic              fill_hit;
    logic              fill_set;

    assign take_snp  = (state == ST_IDLE) && snp_valid;
    assign take_lock = (state == ST_IDLE) && !snp_valid && lock_req;
    assign fill_set  = (state == ST_COMPARE) && !op_lock && !arr_hit && fill_hit;

    snoop_line_match #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W)
    ) u_match (
        .op_addr     (op_addr),
        .rd_tag      (arr_rd_tag),
        .rd_state    (arr_rd_state),
        .fill_active (fill_active),
        .fill_addr   (fill_addr),
        .arr_hit     (arr_hit),
        .arr_dirty   (arr_dirty),
        .fill_hit    (fill_hit)
    );

    snoop_fill_tracker u_fill (
        .clk         (clk),
        .rst_n       (rst_n),
        .fill_active (fill_active),
        .set_en      (fill_set),
        .set_inv     (op_inv),
        .fill_shared (fill_shared),
        .fill_drop   (fill_drop)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (take_snp || take_lock) begin
                    state_nx = ST_READ;
                end
            end
            ST_READ:    state_nx = ST_COMPARE;
            ST_COMPARE: begin
                if (arr_dirty) begin
                    state_nx = ST_WBACK;
                end else if (arr_hit) begin
                    state_nx = ST_WRITE;
                end else begin
                    state_nx = ST_DONE;
                end
            end
            ST_WBACK: begin
                if (wb_done) begin
                    state_nx = ST_WRITE;
                end
            end
            ST_WRITE:   state_nx = ST_DONE;
            ST_DONE:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // Operation capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_addr <= '0;
            op_inv  <= 1'b0;
            op_lock <= 1'b0;
        end else if (take_snp) begin
            op_addr <= snp_addr;
            op_inv  <= snp_inv;
            op_lock <= 1'b0;
        end else if (take_lock) begin
            op_addr <= lock_addr;
            op_inv  <= 1'b1;
            op_lock <= 1'b1;
        end
    end

    // Registered snoop results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_n  <= 1'b1;
            hitm_n <= 1'b1;
        end else if (state == ST_COMPARE && !op_lock) begin
            hit_n  <= !(arr_hit || fill_hit);
            hitm_n <= !arr_dirty;
        end else if (state == ST_DONE) begin
            hit_n  <= 1'b1;
            hitm_n <= 1'b1;
        end
    end

    // Combinational outputs
    always_comb begin
        busy         = (state != ST_IDLE);
        arr_rd_en    = (state == ST_READ);
        arr_rd_idx   = op_addr[OFF_W+IDX_W-1:OFF_W];
        wb_req       = (state == ST_WBACK);
        wb_addr      = {op_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        arr_wr_en    = (state == ST_WRITE);
        arr_wr_idx   = op_addr[OFF_W+IDX_W-1:OFF_W];
        arr_wr_state = (op_inv || op_lock) ? MESI_I : MESI_S;
        lock_ack     = (state == ST_DONE) && op_lock;
    end

endmodule

// File: rtl/snoop_responder_chk.sv
module snoop_responder_chk (
    input logic clk,
    input logic rst_n,
    input logic hit_n,
    input logic hitm_n,
    input logic busy,
    input logic wb_req,
    input logic wb_done,
    input logic arr_wr_en,
    input logic lock_ack,
    input logic fill_shared,
    input logic fill_drop
);

    assert_hitm_needs_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !hitm_n |-> !hit_n);

    assert_idle_releases_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (hit_n && hitm_n));

    assert_hit_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hit_n) |-> busy);

    assert_no_write_in_wb_R11: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_en |-> !wb_req);

    assert_write_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_done) |=> !arr_wr_en);

    assert_wb_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_done) |=> wb_req);

    assert_lock_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lock_ack |-> (hit_n && hitm_n && busy));

    assert_lock_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lock_ack |=> !lock_ack);

    assert_fill_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_shared && fill_drop));

endmodule

bind snoop_responder snoop_responder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit_n       (hit_n),
    .hitm_n      (hitm_n),
    .busy        (busy),
    .wb_req      (wb_req),
    .wb_done     (wb_done),
    .arr_wr_en   (arr_wr_en),
    .lock_ack    (lock_ack),
    .fill_shared (fill_shared),
    .fill_drop   (fill_drop)
);

// File: tb/snoop_responder_bench.sv
module snoop_responder_bench;

    localparam int AW = 32;
    localparam int IW = 7;
    localparam int TW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          snp_valid = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic          snp_inv = 1'b0;
    logic          lock_req = 1'b0;
    logic [AW-1:0] lock_addr = '0;
    logic          lock_ack, hit_n, hitm_n, busy;
    logic          arr_rd_en, arr_wr_en, wb_req;
    logic [IW-1:0] arr_rd_idx, arr_wr_idx;
    logic [TW-1:0] arr_rd_tag = '0;
    logic [1:0]    arr_rd_state = '0;
    logic [1:0]    arr_wr_state;
    logic [AW-1:0] wb_addr;
    logic          wb_done = 1'b0;
    logic          fill_active = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic          fill_shared, fill_drop;

    logic [TW-1:0] mem_tag [128];
    logic [1:0]    mem_st  [128];

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic e_hit_n = 1, e_hitm_n = 1, e_busy = 0, e_wb = 0, e_wr = 0, e_ack = 0;
    logic e_fsh = 0, e_fdr = 0;
    logic [1:0]    e_wr_state = 0;
    logic [IW-1:0] e_wr_idx = 0;
    logic [AW-1:0] e_wb_addr = 0;

    always #5 clk = ~clk;

    snoop_responder u_snoop_responder (
        .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_addr(snp_addr),
        .snp_inv(snp_inv), .lock_req(lock_req), .lock_addr(lock_addr),
        .lock_ack(lock_ack), .hit_n(hit_n), .hitm_n(hitm_n), .busy(busy),
        .arr_rd_en(arr_rd_en), .arr_rd_idx(arr_rd_idx), .arr_rd_tag(arr_rd_tag),
        .arr_rd_state(arr_rd_state), .arr_wr_en(arr_wr_en), .arr_wr_idx(arr_wr_idx),
        .arr_wr_state(arr_wr_state), .wb_req(wb_req), .wb_addr(wb_addr),
        .wb_done(wb_done), .fill_active(fill_active), .fill_addr(fill_addr),
        .fill_shared(fill_shared), .fill_drop(fill_drop)
    );

    // Bench-owned tag/state storage with one-cycle read latency
    always @(posedge clk) begin
        if (arr_rd_en) begin
            arr_rd_tag   <= mem_tag[arr_rd_idx];
            arr_rd_state <= mem_st[arr_rd_idx];
        end
        if (arr_wr_en) mem_st[arr_wr_idx] <= arr_wr_state;
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 20000", cycles);
            finish_run();
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Advance one clock and compare every output against the model
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        chk("R2 hit_n", hit_n, e_hit_n);
        chk("R6 hitm_n", hitm_n, e_hitm_n);
        chk("R7 busy", busy, e_busy);
        chk("R5 wb_req", wb_req, e_wb);
        if (e_wb) chk("R5 wb_addr", wb_addr, e_wb_addr);
        chk("R11 arr_wr_en", arr_wr_en, e_wr);
        if (e_wr) begin
            chk("R4 arr_wr_state", arr_wr_state, e_wr_state);
            chk("R11 arr_wr_idx", arr_wr_idx, e_wr_idx);
        end
        chk("R9 lock_ack", lock_ack, e_ack);
        chk("R8 fill_shared", fill_shared, e_fsh);
        chk("R8 fill_drop", fill_drop, e_fdr);
    endtask

    function automatic logic [AW-1:0] mk(int tg, int idx, int off);
        return {tg[TW-1:0], idx[IW-1:0], off[4:0]};
    endfunction

    task automatic run_op(string tag, bit lk, logic [AW-1:0] a, bit inv, int wbd, bit poke);
        logic [IW-1:0] idx;
        logic [1:0]    st, exp_st, other_st;
        logic [IW-1:0] other_idx;
        bit hit, dirty, fh;
        idx = a[11:5];
        st = mem_st[idx];
        hit = (mem_tag[idx] == a[31:12]) && (st != 2'd0);
        dirty = hit && (st == 2'd3);
        fh = !lk && !hit && fill_active && (fill_addr[31:5] == a[31:5]);
        other_idx = idx + 7'd1;
        other_st = mem_st[other_idx];
        if (lk) begin
            lock_req = 1'b1; lock_addr = a;
        end else begin
            snp_valid = 1'b1; snp_addr = a; snp_inv = inv;
        end
        e_busy = 1;
        step();
        snp_valid = 1'b0;
        step();
        if (!lk) begin
            e_hit_n = !(hit || fh);
            e_hitm_n = !dirty;
        end
        if (fh) begin
            if (inv) begin e_fdr = 1; e_fsh = 0; end
            else e_fsh = !e_fdr;
        end
        e_wr_idx = idx;
        e_wr_state = (lk || inv) ? 2'd0 : 2'd1;
        if (dirty) begin
            e_wb = 1;
            e_wb_addr = {a[31:5], 5'd0};
            step();
            for (int i = 0; i < wbd; i++) begin
                if (poke && i == 0) begin
                    snp_valid = 1'b1; snp_addr = {a[31:12], other_idx, 5'd0}; snp_inv = 1'b1;
                    lock_req = 1'b1; lock_addr = snp_addr;
                end
                step();
                if (poke && i == 0) begin
                    snp_valid = 1'b0;
                    if (!lk) lock_req = 1'b0;
                end
            end
            wb_done = 1'b1; e_wb = 0; e_wr = 1;
            step();
            wb_done = 1'b0;
        end else if (hit) begin
            e_wr = 1;
            step();
        end
        e_wr = 0; e_ack = lk;
        step();
        if (lk) lock_req = 1'b0;
        e_ack = 0; e_busy = 0; e_hit_n = 1; e_hitm_n = 1;
        step();
        exp_st = hit ? ((lk || inv) ? 2'd0 : 2'd1) : st;
        chk(tag, mem_st[idx], exp_st);
        if (poke) begin
            chk("R7 poked line unchanged", mem_st[other_idx], other_st);
            step();
            chk("R7 no second op", busy, 1'b0);
        end
    endtask

    task automatic put(int idx, int tg, logic [1:0] st);
        mem_tag[idx] = tg[TW-1:0];
        mem_st[idx] = st;
    endtask

    initial begin
        for (int i = 0; i < 128; i++) begin
            mem_tag[i] = '0;
            mem_st[i] = 2'd0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        chk("R1 reset hit_n", hit_n, 1'b1);
        chk("R1 reset fill flags", {fill_shared, fill_drop}, 2'b00);

        // Misses
        run_op("R3 miss empty", 0, mk(5, 3, 0), 1, 0, 0);
        put(4, 9, 2'd2);
        run_op("R3 miss tag", 0, mk(8, 4, 4), 1, 0, 0);
        // Clean hits
        put(10, 1, 2'd1);
        run_op("R4 S inv0", 0, mk(1, 10, 8), 0, 0, 0);
        put(11, 2, 2'd2);
        run_op("R4 E inv1", 0, mk(2, 11, 0), 1, 0, 0);
        put(12, 3, 2'd2);
        run_op("R4 E inv0", 0, mk(3, 12, 31), 0, 0, 0);
        // Modified hits
        put(20, 4, 2'd3);
        run_op("R5 M inv1 wait3", 0, mk(4, 20, 12), 1, 3, 0);
        put(21, 5, 2'd3);
        run_op("R5 M inv0 wait0", 0, mk(5, 21, 0), 0, 0, 0);
        // Strobe and lock request during a stalled writeback
        put(30, 6, 2'd3);
        put(31, 6, 2'd1);
        run_op("R7 M with poke", 0, mk(6, 30, 0), 0, 2, 1);
        // Fill in flight
        fill_active = 1'b1;
        fill_addr = mk(7, 40, 0);
        run_op("R8 fill hit inv0", 0, mk(7, 40, 16), 0, 0, 0);
        run_op("R8 fill other line", 0, mk(7, 41, 0), 0, 0, 0);
        run_op("R8 fill hit inv1", 0, mk(7, 40, 4), 1, 0, 0);
        run_op("R8 fill drop sticks", 0, mk(7, 40, 0), 0, 0, 0);
        fill_active = 1'b0;
        e_fsh = 0; e_fdr = 0;
        step();
        // Lock purges
        put(50, 8, 2'd3);
        run_op("R9 lock M", 1, mk(8, 50, 0), 0, 2, 0);
        put(51, 8, 2'd2);
        run_op("R9 lock E", 1, mk(8, 51, 0), 0, 0, 0);
        run_op("R9 lock miss", 1, mk(8, 52, 0), 0, 0, 0);
        // Snoop and lock on the same edge
        put(60, 9, 2'd1);
        put(61, 9, 2'd2);
        lock_req = 1'b1;
        lock_addr = mk(9, 61, 0);
        run_op("R10 snoop first", 0, mk(9, 60, 0), 1, 0, 0);
        chk("R10 lock pending", mem_st[61], 2'd2);
        run_op("R10 lock after", 1, mk(9, 61, 0), 0, 0, 0);
        finish_run();
    end

endmodule